// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache Controller

This block places a 8 KB, two-way set-associative data cache between a processor load/store port and a line-wide main-memory port. Every transfer is one full 32-byte line. Each set keeps two tags with a valid flag, a dirty flag and a policy flag per line, plus one replacement bit per set. A line's policy flag chooses whether write hits are held in the cache (write-back) or are also sent on to memory (write-through). The flag is taken from the `cpu_wt` attribute of the read miss that filled the line.

Read misses bring the line in from memory. A dirty write-back victim is first written out, and the fill request follows it. Write misses go to memory only and never allocate a line. The processor port uses a valid/ready handshake. During any memory activity `cpu_ready` stays low, and the processor holds its request stable until `cpu_ready` is seen high.

Top module: `dc_cache`

## Requirements
- R1: After reset `cpu_ready` and `mem_req` are low with no request pending, and every line is invalid, so the first access to any address misses.
- R2: A read that hits returns the stored line on `cpu_rdata` in the cycle `cpu_ready` is high, with no memory request.
- R3: A read miss issues one memory read for line address `cpu_addr[31:5]`, fills the line and then returns the fetched data, with `cpu_ready` low until then.
- R4: Two lines with different tags and the same set index (`cpu_addr[11:5]`) are held at once, and at most one way hits for any lookup.
- R5: A write miss issues one memory write of `cpu_wdata` to the line address and does not fill, so a later read of that address misses.
- R6: A write hit on a write-back line updates the cached line and marks it dirty, with no memory access.
- R7: A read miss whose victim is a dirty line first writes the victim to memory (address = victim tag and set, data = cached line), then issues the fill read.
- R8: A write hit on a write-through line writes the new data to memory and into the cache, and the line stays clean: evicting it later causes no write-back.
- R9: The victim on a miss is an invalid way if one exists (way 0 first), otherwise the way not accessed most recently; hits and fills both count as accesses.
- R10: While `mem_req` is high and `mem_ack` has not arrived, `mem_req`, `mem_we` and `mem_addr` remain unchanged.
- R11: A line's policy is set by `cpu_wt` on the read miss that fills it; `cpu_wt` on write hits has no effect on that policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wt | input | 1 | Policy for a line filled by this read: 1 = write-through |
| cpu_addr | input | 32 | Byte address; bits [4:0] ignored |
| cpu_wdata | input | 256 | Write line |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | 256 | Read line, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 27 | Line address (tag and set) |
| mem_wdata | output | 256 | Memory write line |
| mem_ack | input | 1 | One-cycle completion of the current memory request |
| mem_rdata | input | 256 | Read line, valid with `mem_ack` |

## Verification
The critical overlap is a read miss that both evicts a dirty line and fetches a new one. Two memory transactions then belong to one processor request, and the replacement bit decides which line leaves. This case is provoked in many sets: one way is dirtied by a write-back hit, the other way is touched most recently by a write-through hit, and then a third tag is read. The bench records the exact order, addresses and data of the memory transactions during that request. It requires a write of the dirtied line followed by a read of the new one, and then confirms that the surviving line still hits.

// File: rtl/dc_pkg.sv
// dc_pkg: shared types of the data cache controller.
// Assumes: nothing beyond IEEE 1800-2017.
package dc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // lookup on the live processor request
        ST_EVICT,  // writing a dirty victim line to memory
        ST_FETCH,  // reading the missing line from memory
        ST_WRMEM,  // write miss or write-through hit going to memory
        ST_DONE    // completing a request that went to memory
    } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
// dc_tag_store: per-way tag, valid, dirty and policy bits, with one
// replacement bit per set. Lookup and victim choice are combinational.
// Assumes: updates for one set only per cycle, at index wr_idx.
module dc_tag_store #(
    parameter int TAG_W = 20,
    parameter int IDX_W = 7,
    parameter int SETS  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             fill_en,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_wt,
    input  logic             dirty_en,
    input  logic             dirty_way,
    output logic             hit,
    output logic             hit_way,
    output logic             hit_wt,
    output logic             vic_way,
    output logic             vic_valid,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag
);
    logic [TAG_W-1:0] tag_q [0:1][0:SETS-1];
    logic [SETS-1:0]  vld_q [0:1];
    logic [SETS-1:0]  drt_q [0:1];
    logic [SETS-1:0]  wt_q  [0:1];
    logic [SETS-1:0]  lru_q;
    logic [1:0]       hit_vec;

    // Tag storage: written only on a fill, needs no reset.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_way][wr_idx] <= fill_tag;
    end

    // Status bits: cleared by reset, set by fills, dirty marks and accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < 2; w++) begin
                vld_q[w] <= '0;
                drt_q[w] <= '0;
                wt_q[w]  <= '0;
            end
            lru_q <= '0;
        end else begin
            if (fill_en) begin
                vld_q[fill_way][wr_idx] <= 1'b1;
                drt_q[fill_way][wr_idx] <= 1'b0;
                wt_q[fill_way][wr_idx]  <= fill_wt;
                lru_q[wr_idx]           <= ~fill_way;
            end
            if (dirty_en) drt_q[dirty_way][wr_idx] <= 1'b1;
            if (touch_en) lru_q[wr_idx] <= ~touch_way;
        end
    end

    // Per-way tag compare.
    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign hit_vec[w] = vld_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag);
    end

    // Hit summary and victim choice: an invalid way first, else the LRU way.
    always_comb begin
        hit     = |hit_vec;
        hit_way = hit_vec[1];
        hit_wt  = wt_q[hit_way][lk_idx];
        if (!vld_q[0][lk_idx])      vic_way = 1'b0;
        else if (!vld_q[1][lk_idx]) vic_way = 1'b1;
        else                        vic_way = lru_q[lk_idx];
        vic_valid = vld_q[vic_way][lk_idx];
        vic_dirty = drt_q[vic_way][lk_idx];
        vic_tag   = tag_q[vic_way][lk_idx];
    end

    assert_single_way_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/dc_line_store.sv
// dc_line_store: line data of both ways, one write port, both ways read
// combinationally at one index.
// Assumes: the controller never writes both ways in one cycle.
module dc_line_store #(
    parameter int LINE_W = 256,
    parameter int IDX_W  = 7,
    parameter int SETS   = 128
) (
    input  logic                   clk,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [1:0][LINE_W-1:0] rd_lines,
    input  logic                   wr_en,
    input  logic                   wr_way,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [LINE_W-1:0]      wr_data
);
    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [LINE_W-1:0] mem_q [0:SETS-1];
        // Line write for this way.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == 1'(w))) mem_q[wr_idx] <= wr_data;
        end
        assign rd_lines[w] = mem_q[rd_idx];
    end
endmodule

// File: rtl/dc_ctrl.sv
// dc_ctrl: request sequencer. It resolves hits in the lookup cycle and runs
// evictions, fills and memory writes for misses and write-through hits.
// Assumes: the processor holds its request stable until cpu_ready is high;
// memory acknowledges each request with a single-cycle mem_ack.
module dc_ctrl
    import dc_pkg::*;
#(
    parameter int TAG_W  = 20,
    parameter int IDX_W  = 7,
    parameter int LINE_W = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_valid,
    input  logic                   cpu_we,
    input  logic                   cpu_wt,
    input  logic [TAG_W-1:0]       cpu_tag,
    input  logic [IDX_W-1:0]       cpu_idx,
    input  logic [LINE_W-1:0]      cpu_wdata,
    output logic                   cpu_ready,
    input  logic                   hit,
    input  logic                   hit_way,
    input  logic                   hit_wt,
    input  logic                   vic_way,
    input  logic                   vic_valid,
    input  logic                   vic_dirty,
    input  logic [TAG_W-1:0]       vic_tag,
    input  logic [1:0][LINE_W-1:0] rd_lines,
    output logic [IDX_W-1:0]       lk_idx,
    output logic                   touch_en,
    output logic                   touch_way,
    output logic                   fill_en,
    output logic                   fill_way,
    output logic [TAG_W-1:0]       fill_tag,
    output logic                   fill_wt,
    output logic                   dirty_en,
    output logic                   dirty_way,
    output logic                   dwr_en,
    output logic                   dwr_way,
    output logic [LINE_W-1:0]      dwr_data,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [TAG_W+IDX_W-1:0] mem_addr,
    output logic [LINE_W-1:0]      mem_wdata,
    input  logic                   mem_ack,
    input  logic [LINE_W-1:0]      mem_rdata
);
    dc_state_e         state;
    logic [TAG_W-1:0]  req_tag, evict_tag;
    logic [IDX_W-1:0]  req_idx;
    logic              req_we, req_wt, req_hit, req_way;
    logic [LINE_W-1:0] req_wdata;
    logic              idle, hit_rd, hit_wb, done_upd;

    // Immediate completions and the shared index for lookup and update.
    always_comb begin
        idle     = (state == ST_IDLE);
        hit_rd   = idle && cpu_valid && hit && !cpu_we;
        hit_wb   = idle && cpu_valid && hit && cpu_we && !hit_wt;
        done_upd = (state == ST_DONE) && req_hit;
        lk_idx   = idle ? cpu_idx : req_idx;
    end

    // Processor handshake and storage update strobes.
    always_comb begin
        cpu_ready = hit_rd || hit_wb || (state == ST_DONE);
        touch_en  = hit_rd || hit_wb || done_upd;
        touch_way = idle ? hit_way : req_way;
        dirty_en  = hit_wb;
        dirty_way = hit_way;
        fill_en   = (state == ST_FETCH) && mem_ack;
        fill_way  = req_way;
        fill_tag  = req_tag;
        fill_wt   = req_wt;
        dwr_en    = hit_wb || fill_en || done_upd;
        dwr_way   = idle ? hit_way : req_way;
        if (idle)                   dwr_data = cpu_wdata;
        else if (state == ST_FETCH) dwr_data = mem_rdata;
        else                        dwr_data = req_wdata;
    end

    // Memory request drive.
    always_comb begin
        mem_req   = (state == ST_EVICT) || (state == ST_FETCH) || (state == ST_WRMEM);
        mem_we    = (state == ST_EVICT) || (state == ST_WRMEM);
        mem_addr  = (state == ST_EVICT) ? {evict_tag, req_idx} : {req_tag, req_idx};
        mem_wdata = (state == ST_EVICT) ? rd_lines[req_way] : req_wdata;
    end

    // Sequencer state and captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            req_we  <= 1'b0;
            req_hit <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cpu_valid && !hit_rd && !hit_wb) begin
                        req_tag   <= cpu_tag;
                        req_idx   <= cpu_idx;
                        req_we    <= cpu_we;
                        req_wt    <= cpu_wt;
                        req_wdata <= cpu_wdata;
                        req_hit   <= hit;
                        if (hit) begin
                            req_way <= hit_way;
                            state   <= ST_WRMEM;
                        end else if (cpu_we) begin
                            state   <= ST_WRMEM;
                        end else begin
                            req_way   <= vic_way;
                            evict_tag <= vic_tag;
                            state     <= (vic_valid && vic_dirty) ? ST_EVICT : ST_FETCH;
                        end
                    end
                end
                ST_EVICT: if (mem_ack) state <= ST_FETCH;
                ST_FETCH: if (mem_ack) state <= ST_IDLE;
                ST_WRMEM: if (mem_ack) state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    assert_no_write_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |-> !req_we);
    assert_evict_then_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVICT && mem_ack) |=> (state == ST_FETCH));
    assert_ready_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && idle) |-> !mem_req);
endmodule

// File: rtl/dc_cache.sv
// dc_cache: top of the two-way data cache controller. It joins the
// sequencer, the tag/status store and the line store.
// Assumes: line-wide transfers on both ports; address bits below the line
// offset are ignored.
module dc_cache #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int LA_W      = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic              cpu_wt,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [LINE_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [LINE_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [LA_W-1:0]   mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    logic [TAG_W-1:0]       cpu_tag, fill_tag, vic_tag;
    logic [IDX_W-1:0]       cpu_idx, lk_idx;
    logic                   hit, hit_way, hit_wt, vic_way, vic_valid, vic_dirty;
    logic                   touch_en, touch_way, fill_en, fill_way, fill_wt;
    logic                   dirty_en, dirty_way, dwr_en, dwr_way;
    logic [LINE_W-1:0]      dwr_data;
    logic [1:0][LINE_W-1:0] rd_lines;

    assign cpu_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_idx   = cpu_addr[OFF_W +: IDX_W];
    assign cpu_rdata = rd_lines[hit_way];

    dc_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_wt(cpu_wt),
        .cpu_tag(cpu_tag), .cpu_idx(cpu_idx), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready),
        .hit(hit), .hit_way(hit_way), .hit_wt(hit_wt),
        .vic_way(vic_way), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
        .vic_tag(vic_tag), .rd_lines(rd_lines), .lk_idx(lk_idx),
        .touch_en(touch_en), .touch_way(touch_way),
        .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_wt(fill_wt), .dirty_en(dirty_en), .dirty_way(dirty_way),
        .dwr_en(dwr_en), .dwr_way(dwr_way), .dwr_data(dwr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    dc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .SETS(SETS)) u_tags (
        .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_tag(cpu_tag),
        .wr_idx(lk_idx), .touch_en(touch_en), .touch_way(touch_way),
        .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_wt(fill_wt), .dirty_en(dirty_en), .dirty_way(dirty_way),
        .hit(hit), .hit_way(hit_way), .hit_wt(hit_wt),
        .vic_way(vic_way), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
        .vic_tag(vic_tag)
    );

    dc_line_store #(.LINE_W(LINE_W), .IDX_W(IDX_W), .SETS(SETS)) u_lines (
        .clk(clk), .rd_idx(lk_idx), .rd_lines(rd_lines),
        .wr_en(dwr_en), .wr_way(dwr_way), .wr_idx(lk_idx), .wr_data(dwr_data)
    );
endmodule

// File: tb/dc_cache_bench.sv
// dc_cache_bench: sweeps a fixed access script over many sets against a
// line-wide memory model, comparing data and memory traffic with values
// computed from the requirements.
module dc_cache_bench;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_valid = 1'b0, cpu_we = 1'b0, cpu_wt = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [255:0] cpu_wdata = '0;
    logic         cpu_ready;
    logic [255:0] cpu_rdata;
    logic         mem_req, mem_we;
    logic [26:0]  mem_addr;
    logic [255:0] mem_wdata;
    logic         mem_ack = 1'b0;
    logic [255:0] mem_rdata = '0;

    int checks = 0, fails = 0;

    dc_cache u_dc_cache (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_wt(cpu_wt), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(PERIOD/2) clk = ~clk;

    // Memory model: two wait cycles, then a one-cycle acknowledge. Logs every
    // transaction of the current processor request.
    logic [255:0] store [int];
    int           ev_n = 0;
    bit           ev_we [0:7];
    logic [26:0]  ev_addr [0:7];
    logic [255:0] ev_data [0:7];
    int           lat = 0;
    logic [26:0]  held_addr;
    logic         held_we;

    function automatic logic [255:0] pat(input logic [26:0] la);
        return {8{{5'd0, la} ^ 32'h5A17_C3E9}};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (lat == 0) begin
                held_addr = mem_addr;
                held_we   = mem_we;
            end else begin
                check(mem_addr == held_addr && mem_we == held_we, "R10",
                      "request held", {228'd0, mem_we, mem_addr}, {228'd0, held_we, held_addr});
            end
            if (lat == 2) begin
                lat <= 0;
                mem_ack <= 1'b1;
                if (ev_n < 8) begin
                    ev_we[ev_n]   = mem_we;
                    ev_addr[ev_n] = mem_addr;
                    ev_data[ev_n] = mem_wdata;
                end
                ev_n = ev_n + 1;
                if (mem_we) store[int'(mem_addr)] = mem_wdata;
                else mem_rdata <= store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : pat(mem_addr);
            end else begin
                lat <= lat + 1;
            end
        end
    end

    task automatic access(input bit we, input bit wt, input logic [26:0] la,
                          input logic [255:0] wd, output logic [255:0] rd);
        int n = 0;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_wt = wt;
        cpu_addr = {la, 5'b10101}; cpu_wdata = wd; ev_n = 0;
        #1;
        while (!cpu_ready && n < 2000) begin
            @(negedge clk); #1; n++;
        end
        if (n >= 2000) check(1'b0, "R3", "request hung", 256'(n), 256'd0);
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_valid = 1'b0;
    endtask

    task automatic expect_ev(input int i, input bit we, input logic [26:0] la,
                             input string req);
        check(ev_we[i] == we && ev_addr[i] == la, req, "memory transaction",
              {228'd0, ev_we[i], ev_addr[i]}, {228'd0, we, la});
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [255:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!cpu_ready && !mem_req, "R1", "idle after reset",
              {254'd0, cpu_ready, mem_req}, 256'd0);

        for (int s = 0; s < 128; s += 9) begin
            logic [26:0]  la_a, la_b, la_c, la_d;
            logic [255:0] d_a, d_b, d_d;
            la_a = {20'h01000 + 20'(s), 7'(s)};
            la_b = {20'h02000 + 20'(s), 7'(s)};
            la_c = {20'h03000 + 20'(s), 7'(s)};
            la_d = {20'h04000 + 20'(s), 7'(s)};
            d_a  = {8{32'hA0000000 | 32'(s)}};
            d_b  = {8{32'hB0000000 | 32'(s)}};
            d_d  = {8{32'hD0000000 | 32'(s)}};

            // R1/R3: cold read miss fetches and returns the line (write-back policy).
            access(0, 0, la_a, '0, rd);
            check(ev_n == 1, "R1", "cold miss traffic", 256'(ev_n), 256'd1);
            expect_ev(0, 0, la_a, "R3");
            check(rd == pat(la_a), "R3", "fill data", rd, pat(la_a));
            // R2: read hit, no traffic.
            access(0, 0, la_a, '0, rd);
            check(ev_n == 0 && rd == pat(la_a), "R2", "read hit", rd, pat(la_a));
            // R4: second tag fills the other way (write-through policy), first still hits.
            access(0, 1, la_b, '0, rd);
            check(ev_n == 1 && rd == pat(la_b), "R4", "second way fill", rd, pat(la_b));
            access(0, 0, la_a, '0, rd);
            check(ev_n == 0 && rd == pat(la_a), "R4", "both ways resident", rd, pat(la_a));
            // R6/R11: write hit on write-back line stays in cache though cpu_wt=1.
            access(1, 1, la_a, d_a, rd);
            check(ev_n == 0, "R11", "write-back hit traffic", 256'(ev_n), 256'd0);
            access(0, 0, la_a, '0, rd);
            check(ev_n == 0 && rd == d_a, "R6", "updated line", rd, d_a);
            // R8/R11: write hit on write-through line goes to memory though cpu_wt=0.
            access(1, 0, la_b, d_b, rd);
            check(ev_n == 1, "R8", "write-through traffic", 256'(ev_n), 256'd1);
            expect_ev(0, 1, la_b, "R8");
            check(ev_data[0] == d_b, "R8", "write-through data", ev_data[0], d_b);
            access(0, 0, la_b, '0, rd);
            check(ev_n == 0 && rd == d_b, "R8", "cached write-through line", rd, d_b);
            // R7/R9: miss evicts the dirty LRU line, then fetches.
            access(0, 0, la_c, '0, rd);
            check(ev_n == 2, "R7", "evict plus fill count", 256'(ev_n), 256'd2);
            expect_ev(0, 1, la_a, "R9");
            check(ev_data[0] == d_a, "R7", "evicted data", ev_data[0], d_a);
            expect_ev(1, 0, la_c, "R7");
            check(rd == pat(la_c), "R7", "fill after evict", rd, pat(la_c));
            // R5: write miss writes memory only.
            access(1, 0, la_d, d_d, rd);
            check(ev_n == 1, "R5", "write miss traffic", 256'(ev_n), 256'd1);
            expect_ev(0, 1, la_d, "R5");
            // R5/R8: later read misses; clean write-through victim needs no write-back.
            access(0, 0, la_d, '0, rd);
            check(ev_n == 1, "R8", "clean victim no write-back", 256'(ev_n), 256'd1);
            expect_ev(0, 0, la_d, "R5");
            check(rd == d_d, "R5", "data from memory", rd, d_d);
            // R9: the most recently used line survived.
            access(0, 0, la_c, '0, rd);
            check(ev_n == 0 && rd == pat(la_c), "R9", "survivor hits", rd, pat(la_c));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule